// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block sits in front of the ALU of a five-stage in-order pipeline (fetch, decode, execute, memory access, writeback) whose register file holds 32 entries. Every instruction carries its destination index, write enable and result through the stage registers that follow execute. The unit compares the two source register indices of the instruction now in execute against the destinations of the two older instructions still in flight, in the memory and writeback stages. When one of them is about to write a source register, the unit substitutes that in-flight result for the stale register-file read. A dependent instruction issued one or two slots behind its producer therefore runs without waiting for writeback.

Register 0 is hard-wired to zero, so an in-flight write aimed at index 0 is never bypassed. Register 31, which jump-and-link writes implicitly, is handled like any other destination. A parameter chooses how a source index of 0 is served: either the operand is forced to zero inside the unit, or the register-file read passes through untouched. The unit is purely combinational. Load-use stalls, the register file itself and branch hazards are handled elsewhere.

Top module: `fwd_unit`

## Requirements
- R1: When neither later stage targets a source index, that operand equals its register-file read value.
- R2: When the memory stage has its write enable at 1 and a nonzero destination equal to the source index, the operand equals the memory-stage result.
- R3: When only the writeback stage has its write enable at 1 and a nonzero destination equal to the source index, the operand equals the writeback-stage result.
- R4: When both later stages match the same source index, the memory-stage (younger) result is used.
- R5: A stage whose write enable is 0 never supplies an operand, whatever its destination index.
- R6: A destination index of 0 never produces a match. With HARD_ZERO_R0 = 0, source index 0 yields the register-file read value.
- R7: With HARD_ZERO_R0 = 1 (the default), source index 0 yields an all-zero operand whatever the read value and the stage inputs.
- R8: Index 31 is forwarded from either stage exactly like any other nonzero index.
- R9: The two operands are resolved independently with identical priority. Each depends only on its own index and read value and on the shared stage inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register index of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register index of the execute-stage instruction |
| ex_rd_a | input | 32 | Register-file read value for the first source |
| ex_rd_b | input | 32 | Register-file read value for the second source |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_dst | input | 5 | Memory-stage destination index |
| mem_res | input | 32 | Memory-stage result |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_dst | input | 5 | Writeback-stage destination index |
| wb_res | input | 32 | Writeback-stage result |
| alu_a | output | 32 | Resolved first operand |
| alu_b | output | 32 | Resolved second operand |

## Verification
The bench sweeps every combination of the first source index, both destination indices and both write enables. Each operand, stage result and read value carries a distinct tag, so a wrong choice shows up as the wrong tag. A design that reversed the stage priority would hand an instruction the older writeback value when both stages match. One that ignored the write enable would forward data from stores and branches. One that dropped the nonzero test would leak a discarded write to r0 into an operand, which the second instance with the zero-forcing option off exposes. Because the second source index is swept in the opposite direction from the first, the sweep also catches an operand that takes the other operand's selection.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   // Producer stages, ordered youngest first; lower index wins a tie.
   localparam int unsigned NPROD     = 2;
   localparam int unsigned STAGE_MEM = 0;
   localparam int unsigned STAGE_WB  = 1;
   localparam int unsigned NSRC      = 2;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int unsigned AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic          wen,
   input  logic [AW-1:0] dst,
   output logic          hit
);
   // A write to index 0 is discarded by the register file, so never bypass it.
   assign hit = wen && (dst != '0) && (dst == src);

   always_comb begin
      if (dst == '0) a_r6_no_zero_hit: assert (!hit) else $error("r0 destination matched");
      if (!wen)      a_r5_wen_gates:   assert (!hit) else $error("disabled stage matched");
   end
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand #(
   parameter int unsigned XLEN  = 32,
   parameter int unsigned AW    = 5,
   parameter int unsigned NPROD = 2
) (
   input  logic [AW-1:0]               src,
   input  logic [XLEN-1:0]             rf_val,
   input  logic [NPROD-1:0]            p_wen,
   input  logic [NPROD-1:0][AW-1:0]    p_dst,
   input  logic [NPROD-1:0][XLEN-1:0]  p_val,
   output logic [XLEN-1:0]             opnd
);
   logic [NPROD-1:0] hit;
   logic [NPROD-1:0] grant;

   for (genvar g = 0; g < NPROD; g++) begin : g_cmp
      fwd_match #(.AW(AW)) u_match (
         .src (src),
         .wen (p_wen[g]),
         .dst (p_dst[g]),
         .hit (hit[g])
      );
   end

   // Fixed priority: the youngest matching stage gets the grant.
   always_comb begin
      logic found;
      found = 1'b0;
      grant = '0;
      for (int i = 0; i < NPROD; i++) begin
         if (hit[i] && !found) begin
            grant[i] = 1'b1;
            found    = 1'b1;
         end
      end
   end

   always_comb begin
      opnd = rf_val;
      for (int i = 0; i < NPROD; i++) begin
         if (grant[i]) opnd = p_val[i];
      end
   end

   always_comb begin
      a_r4_single_grant: assert ($onehot0(grant)) else $error("several stages granted");
      if (hit == '0) a_r1_passthru: assert (opnd == rf_val) else $error("operand altered without match");
      if (hit[0])    a_r4_young_wins: assert (opnd == p_val[0]) else $error("youngest match not used");
      if (p_wen == '0) a_r5_idle: assert (opnd == rf_val) else $error("idle stages changed operand");
   end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned NREG         = 32,
   parameter bit          HARD_ZERO_R0 = 1'b1,
   localparam int unsigned AW          = $clog2(NREG)
) (
   input  logic [AW-1:0]   ex_src_a,
   input  logic [AW-1:0]   ex_src_b,
   input  logic [XLEN-1:0] ex_rd_a,
   input  logic [XLEN-1:0] ex_rd_b,
   input  logic            mem_wen,
   input  logic [AW-1:0]   mem_dst,
   input  logic [XLEN-1:0] mem_res,
   input  logic            wb_wen,
   input  logic [AW-1:0]   wb_dst,
   input  logic [XLEN-1:0] wb_res,
   output logic [XLEN-1:0] alu_a,
   output logic [XLEN-1:0] alu_b
);
   if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two of at least 2");
   end
   if (XLEN < 1) begin : g_bad_xlen
      $error("XLEN must be positive");
   end

   logic [NPROD-1:0]           p_wen;
   logic [NPROD-1:0][AW-1:0]   p_dst;
   logic [NPROD-1:0][XLEN-1:0] p_val;

   assign p_wen[STAGE_MEM] = mem_wen;
   assign p_dst[STAGE_MEM] = mem_dst;
   assign p_val[STAGE_MEM] = mem_res;
   assign p_wen[STAGE_WB]  = wb_wen;
   assign p_dst[STAGE_WB]  = wb_dst;
   assign p_val[STAGE_WB]  = wb_res;

   logic [NSRC-1:0][AW-1:0]   src;
   logic [NSRC-1:0][XLEN-1:0] rdv;
   logic [NSRC-1:0][XLEN-1:0] fwd;
   logic [NSRC-1:0][XLEN-1:0] res;

   assign src[0] = ex_src_a;
   assign src[1] = ex_src_b;
   assign rdv[0] = ex_rd_a;
   assign rdv[1] = ex_rd_b;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      fwd_operand #(.XLEN(XLEN), .AW(AW), .NPROD(NPROD)) u_opnd (
         .src    (src[s]),
         .rf_val (rdv[s]),
         .p_wen  (p_wen),
         .p_dst  (p_dst),
         .p_val  (p_val),
         .opnd   (fwd[s])
      );
      if (HARD_ZERO_R0) begin : g_zero
         assign res[s] = (src[s] == '0) ? '0 : fwd[s];
      end else begin : g_pass
         assign res[s] = fwd[s];
      end
   end

   assign alu_a = res[0];
   assign alu_b = res[1];

   always_comb begin
      if (HARD_ZERO_R0 && ex_src_a == '0) a_r7_zero_a: assert (alu_a == '0) else $error("r0 operand A nonzero");
      if (HARD_ZERO_R0 && ex_src_b == '0) a_r7_zero_b: assert (alu_b == '0) else $error("r0 operand B nonzero");
      if (ex_src_a == ex_src_b && ex_rd_a == ex_rd_b)
         a_r9_same_inputs: assert (alu_a == alu_b) else $error("operands resolved differently");
   end
endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [4:0]  src_a, src_b, mdst, wdst;
   logic [31:0] rda, rdb, mres, wres;
   logic        mwen, wwen;
   logic [31:0] a1, b1, a0, b0;

   fwd_unit dut (
      .ex_src_a(src_a), .ex_src_b(src_b), .ex_rd_a(rda), .ex_rd_b(rdb),
      .mem_wen(mwen), .mem_dst(mdst), .mem_res(mres),
      .wb_wen(wwen), .wb_dst(wdst), .wb_res(wres),
      .alu_a(a1), .alu_b(b1));

   fwd_unit #(.HARD_ZERO_R0(1'b0)) dut_nz (
      .ex_src_a(src_a), .ex_src_b(src_b), .ex_rd_a(rda), .ex_rd_b(rdb),
      .mem_wen(mwen), .mem_dst(mdst), .mem_res(mres),
      .wb_wen(wwen), .wb_dst(wdst), .wb_res(wres),
      .alu_a(a0), .alu_b(b0));

   function automatic logic [31:0] expect_op(input logic [4:0] s, input logic [31:0] rf, input bit hz);
      if (hz && s == 5'd0)                       return 32'd0;
      if (mwen && mdst != 5'd0 && mdst == s)     return mres;
      if (wwen && wdst != 5'd0 && wdst == s)     return wres;
      return rf;
   endfunction

   function automatic string tag_of(input logic [4:0] s, input bit hz);
      bit mh, wh;
      mh = mwen && mdst != 5'd0 && mdst == s;
      wh = wwen && wdst != 5'd0 && wdst == s;
      if (hz && s == 5'd0) return "R7";
      if (s == 5'd0)        return "R6";
      if (mh && wh)         return "R4";
      if (mh)               return (s == 5'd31) ? "R8" : "R2";
      if (wh)               return (s == 5'd31) ? "R8" : "R3";
      if (!mwen || !wwen)   return "R5";
      return "R1";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h src_a=%0d src_b=%0d mdst=%0d mwen=%0b wdst=%0d wwen=%0b",
                  req, act, exp, src_a, src_b, mdst, mwen, wdst, wwen);
      end
   endtask

   task automatic check_all();
      #1;
      check(tag_of(src_a, 1'b1), a1, expect_op(src_a, rda, 1'b1));
      check(tag_of(src_b, 1'b1), b1, expect_op(src_b, rdb, 1'b1));
      check(tag_of(src_a, 1'b0), a0, expect_op(src_a, rda, 1'b0));
      check(tag_of(src_b, 1'b0), b0, expect_op(src_b, rdb, 1'b0));
      #1;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // Reset-like idle state: nothing in flight, operands pass through (R1, R5).
      src_a = 5'd3; src_b = 5'd4; rda = 32'h1111_0003; rdb = 32'h2222_0004;
      mwen = 1'b0; mdst = 5'd0; mres = 32'hBBBB_0000;
      wwen = 1'b0; wdst = 5'd0; wres = 32'hCCCC_0000;
      check_all();

      // Directed R4: both stages target r5; memory result must win.
      src_a = 5'd5; mwen = 1'b1; mdst = 5'd5; wwen = 1'b1; wdst = 5'd5;
      #1; check("R4", a1, mres); #1;

      // Directed R8: r31 written by writeback (link value) forwards.
      src_b = 5'd31; mwen = 1'b0; wdst = 5'd31; wres = 32'h0000_0042;
      #1; check("R8", b1, 32'h0000_0042); #1;

      // Directed R6: a write to r0 in flight is not bypassed when no zero forcing.
      src_a = 5'd0; rda = 32'h0; mwen = 1'b1; mdst = 5'd0; mres = 32'hDEAD_BEEF;
      #1; check("R6", a0, 32'h0); check("R7", a1, 32'h0); #1;

      // Near-exhaustive sweep: R1..R9 with distinct tags per value.
      for (int sa = 0; sa < 32; sa++) begin
         for (int md = 0; md < 32; md++) begin
            for (int wd = 0; wd < 32; wd++) begin
               for (int en = 0; en < 4; en++) begin
                  src_a = sa[4:0];
                  src_b = 5'(31 - sa);
                  rda   = 32'hA000_0000 | 32'(sa);
                  rdb   = 32'hD000_0000 | 32'(31 - sa);
                  mdst  = md[4:0];
                  wdst  = wd[4:0];
                  mwen  = en[0];
                  wwen  = en[1];
                  mres  = 32'hB000_0000 | 32'(md << 8) | 32'(en);
                  wres  = 32'hC000_0000 | 32'(wd << 8) | 32'(en);
                  #1;
                  check(tag_of(src_a, 1'b1), a1, expect_op(src_a, rda, 1'b1));
                  check(tag_of(src_b, 1'b1), b1, expect_op(src_b, rdb, 1'b1));
                  check(tag_of(src_a, 1'b0), a0, expect_op(src_a, rda, 1'b0));
                  check(tag_of(src_b, 1'b0), b0, expect_op(src_b, rdb, 1'b0));
               end
            end
         end
      end

      // R9: same index on both operands, distinct read values, forwarded identically.
      src_a = 5'd9; src_b = 5'd9; rda = 32'h1; rdb = 32'h2;
      mwen = 1'b0; wwen = 1'b1; wdst = 5'd9; wres = 32'h0909_0909;
      #1; check("R9", a1, 32'h0909_0909); check("R9", b1, 32'h0909_0909); #1;
      wwen = 1'b0;
      #1; check("R9", a1, 32'h1); check("R9", b1, 32'h2); #1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule